// File: doc/BRIEF.md
# Page Write Collector with Commit Gate

This block sits behind a serial memory front end. The front end turns each serial clock into a one-cycle bit strobe and, on every eighth bit, also gives a byte strobe together with the assembled byte. From that stream the block tracks the command sequence inside one chip-select window. It collects page-write data into a page buffer whose write pointer wraps inside the page. It holds the single data byte of a status-register write. When a write-enable command is closed cleanly, it flags that as well.

When chip select is released, the block decides whether the sequence counts. A sequence counts only if the release comes exactly on a byte boundary after at least one complete data byte. In that case it raises a one-cycle commit request for the status and protection unit downstream. A page commit carries the page-aligned base address, a mask of the byte lanes actually received, and the buffered page data. A status commit carries the received byte with its unused bits cleared. The nonvolatile array and the protection decision are not part of this block.

The sequencer is a state machine with eight states. `ST_OPC` waits for an opcode and is also the resting state while deselected. `ST_AHI` and `ST_ALO` take the two address bytes. `ST_DATA` takes page data. `ST_SRDAT` waits for the status byte, and `ST_SRFULL` holds after it has arrived. `ST_WRENOK` follows a write-enable opcode. `ST_SKIP` absorbs the rest of a cancelled or unknown sequence.

The transitions are as follows:
- Deselect returns any state to `ST_OPC`.
- A byte in `ST_OPC` leads to `ST_AHI` for the page-write opcode, to `ST_SRDAT` for the status-write opcode, to `ST_WRENOK` for write-enable, and to `ST_SKIP` for anything else.
- A byte moves `ST_AHI` to `ST_ALO`, `ST_ALO` to `ST_DATA`, and `ST_SRDAT` to `ST_SRFULL`.
- Any further bit in `ST_SRFULL` or `ST_WRENOK` leads to `ST_SKIP`.
- `ST_DATA` and `ST_SKIP` hold until deselect.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, `commit_o`, `commit_sr_o` and `wel_set_o` are low and `commit_mask_o` is all zero.
- R2: Page-write sequences use opcode 0x02 followed by two address bytes (high byte first) and 1 to 64 data bytes. If chip select then rises with the bit count on a byte boundary, `commit_o` pulses with `commit_sr_o` low. `commit_mask_o` bit i is set for each received page offset i, and `commit_data_o[8*i+7:8*i]` holds the byte last written there.
- R3: Data bytes are placed at consecutive offsets starting from the address offset. Past offset 63 the offset returns to 0 of the same page, and later bytes overwrite earlier ones.
- R4: If chip select rises while 1 to 7 bits of a data byte have been clocked, no commit is raised.
- R5: If chip select rises before a complete data byte has arrived (during the opcode, during the address, or right after the address), no commit is raised.
- R6: Status-write sequences use opcode 0x01 followed by exactly one byte and a boundary release. They pulse `commit_o` and `commit_sr_o` together, with `sr_data_o` equal to the byte with bits 6, 5, 1 and 0 forced to 0. Any extra bit after that byte cancels the sequence.
- R7: A write-enable opcode 0x06 followed directly by a chip-select rise pulses `wel_set_o`. If any further bit follows in the same selection, there is no `wel_set_o` and no commit, even for a complete page write that follows it.
- R8: The lane mask is cleared at each page-write opcode, so a commit shows only the lanes of its own sequence.
- R9: Every pulse lasts exactly one cycle and appears in the cycle after the first clock that samples `cs_n` high.
- R10: Any other opcode produces no commit and no `wel_set_o`, whatever follows it.
- R11: `commit_base_o` is the received address, reduced to ADDR_W bits (address bit 15 ignored at the default), with the low six offset bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| bit_stb | input | 1 | One serial bit was clocked in |
| byte_stb | input | 1 | Eighth bit of a byte, coincident with bit_stb |
| byte_dat | input | 8 | Assembled byte, valid with byte_stb |
| commit_o | output | 1 | One-cycle commit request |
| commit_sr_o | output | 1 | Commit targets the status register |
| commit_base_o | output | ADDR_W | Page-aligned base address |
| commit_mask_o | output | PAGE_BYTES | Received byte lanes |
| commit_data_o | output | 8*PAGE_BYTES | Buffered page data, lane i at bits 8i+7..8i |
| sr_data_o | output | 8 | Status byte with unused bits cleared |
| wel_set_o | output | 1 | Write enable closed correctly |

## Verification
The bench sweeps data-byte counts from 1 to 70 at page offsets 0, 5 and 63. This exposes a design that does not wrap the pointer, that wraps to the wrong page, or that keeps stale lanes from the previous write. Releases after every partial bit count from 1 to 7 target a design that tests only for the data state and commits truncated bytes. All 256 status values catch a wrong bit mask. Releases during the address phase, write-enable followed by more traffic, and unknown opcodes catch a sequencer that reacts to the wrong state.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_AHI,
        ST_ALO,
        ST_DATA,
        ST_SRDAT,
        ST_SRFULL,
        ST_WRENOK,
        ST_SKIP
    } seq_st_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_PAGE,
        ACT_SR,
        ACT_WEL
    } close_act_e;

    localparam logic [BYTE_W-1:0] OPC_PAGE_WR = 8'h02;
    localparam logic [BYTE_W-1:0] OPC_SR_WR   = 8'h01;
    localparam logic [BYTE_W-1:0] OPC_WR_EN   = 8'h06;
    // status bits that survive: 7, 4, 3, 2
    localparam logic [BYTE_W-1:0] SR_KEEP     = 8'h9C;
endpackage

// File: rtl/pgwr_bitpos.sv
module pgwr_bitpos #(
    parameter int BITS_PER_BYTE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic bit_stb,
    output logic cs_rise,
    output logic on_bound
);
    localparam int CNT_W = $clog2(BITS_PER_BYTE);

    logic [CNT_W-1:0] cnt_q;
    logic             cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            cnt_q <= '0;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                cnt_q <= '0;
            end else if (bit_stb) begin
                if (cnt_q == CNT_W'(BITS_PER_BYTE - 1)) cnt_q <= '0;
                else                                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cs_rise  = cs_n & ~cs_q;
    assign on_bound = (cnt_q == '0);
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              bit_stb,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_dat,
    input  logic              cs_rise,
    input  logic              on_bound,
    input  logic              any_byte,
    output logic              clr_mask,
    output logic              ld_ahi,
    output logic              ld_alo,
    output logic              wr_byte,
    output logic              commit_o,
    output logic              commit_sr_o,
    output logic              wel_set_o,
    output logic [BYTE_W-1:0] sr_data_o
);
    seq_st_e    st_q, st_d;
    close_act_e act;
    logic       ld_sr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OPC;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d = ST_OPC;
        end else begin
            unique case (st_q)
                ST_OPC: if (byte_stb) begin
                    if (byte_dat == OPC_PAGE_WR)    st_d = ST_AHI;
                    else if (byte_dat == OPC_SR_WR) st_d = ST_SRDAT;
                    else if (byte_dat == OPC_WR_EN) st_d = ST_WRENOK;
                    else                            st_d = ST_SKIP;
                end
                ST_AHI:    if (byte_stb) st_d = ST_ALO;
                ST_ALO:    if (byte_stb) st_d = ST_DATA;
                ST_DATA:   st_d = ST_DATA;
                ST_SRDAT:  if (byte_stb) st_d = ST_SRFULL;
                ST_SRFULL: if (bit_stb)  st_d = ST_SKIP;
                ST_WRENOK: if (bit_stb)  st_d = ST_SKIP;
                ST_SKIP:   st_d = ST_SKIP;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        clr_mask = 1'b0;
        ld_ahi   = 1'b0;
        ld_alo   = 1'b0;
        wr_byte  = 1'b0;
        ld_sr    = 1'b0;
        act      = ACT_NONE;
        unique case (st_q)
            ST_OPC:    clr_mask = !cs_n && byte_stb && (byte_dat == OPC_PAGE_WR);
            ST_AHI:    ld_ahi   = !cs_n && byte_stb;
            ST_ALO:    ld_alo   = !cs_n && byte_stb;
            ST_DATA: begin
                wr_byte = !cs_n && byte_stb;
                if (cs_rise && on_bound && any_byte) act = ACT_PAGE;
            end
            ST_SRDAT:  ld_sr = !cs_n && byte_stb;
            ST_SRFULL: if (cs_rise && on_bound) act = ACT_SR;
            ST_WRENOK: if (cs_rise && on_bound) act = ACT_WEL;
            ST_SKIP:   act = ACT_NONE;
        endcase
    end

    // registered request pulses and status byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_o    <= 1'b0;
            commit_sr_o <= 1'b0;
            wel_set_o   <= 1'b0;
            sr_data_o   <= '0;
        end else begin
            commit_o    <= (act == ACT_PAGE) || (act == ACT_SR);
            commit_sr_o <= (act == ACT_SR);
            wel_set_o   <= (act == ACT_WEL);
            if (ld_sr) sr_data_o <= byte_dat & SR_KEEP;
        end
    end
endmodule

// File: rtl/pgwr_page.sv
module pgwr_page
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_ahi,
    input  logic                         ld_alo,
    input  logic                         clr_mask,
    input  logic                         wr_byte,
    input  logic [BYTE_W-1:0]            byte_dat,
    output logic [ADDR_W-1:0]            base,
    output logic [PAGE_BYTES-1:0]        mask,
    output logic [PAGE_BYTES*BYTE_W-1:0] data,
    output logic                         any_byte
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int HI_W   = ADDR_W - BYTE_W;

    logic [HI_W-1:0]   hi_q;
    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  ptr_q;
    logic [ADDR_W-1:0] start;

    assign start = {hi_q, byte_dat};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            page_q <= '0;
            ptr_q  <= '0;
        end else begin
            if (ld_ahi) hi_q <= byte_dat[HI_W-1:0];
            if (ld_alo) begin
                page_q <= start[ADDR_W-1:OFS_W];
                ptr_q  <= start[OFS_W-1:0];
            end else if (wr_byte) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
        logic              hit;
        logic              m_q;
        logic [BYTE_W-1:0] d_q;
        assign hit = wr_byte && (ptr_q == OFS_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m_q <= 1'b0;
                d_q <= '0;
            end else begin
                if (clr_mask) m_q <= 1'b0;
                else if (hit) m_q <= 1'b1;
                if (hit) d_q <= byte_dat;
            end
        end
        assign mask[i] = m_q;
        assign data[i*BYTE_W +: BYTE_W] = d_q;
    end

    assign base     = {page_q, {OFS_W{1'b0}}};
    assign any_byte = |mask;
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         bit_stb,
    input  logic                         byte_stb,
    input  logic [7:0]                   byte_dat,
    output logic                         commit_o,
    output logic                         commit_sr_o,
    output logic [ADDR_W-1:0]            commit_base_o,
    output logic [PAGE_BYTES-1:0]        commit_mask_o,
    output logic [PAGE_BYTES*8-1:0]      commit_data_o,
    output logic [7:0]                   sr_data_o,
    output logic                         wel_set_o
);
    logic cs_rise, on_bound, any_byte;
    logic clr_mask, ld_ahi, ld_alo, wr_byte;

    pgwr_bitpos #(.BITS_PER_BYTE(BYTE_W)) u_bitpos (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .bit_stb  (bit_stb),
        .cs_rise  (cs_rise),
        .on_bound (on_bound)
    );

    pgwr_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .bit_stb     (bit_stb),
        .byte_stb    (byte_stb),
        .byte_dat    (byte_dat),
        .cs_rise     (cs_rise),
        .on_bound    (on_bound),
        .any_byte    (any_byte),
        .clr_mask    (clr_mask),
        .ld_ahi      (ld_ahi),
        .ld_alo      (ld_alo),
        .wr_byte     (wr_byte),
        .commit_o    (commit_o),
        .commit_sr_o (commit_sr_o),
        .wel_set_o   (wel_set_o),
        .sr_data_o   (sr_data_o)
    );

    pgwr_page #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_ahi   (ld_ahi),
        .ld_alo   (ld_alo),
        .clr_mask (clr_mask),
        .wr_byte  (wr_byte),
        .byte_dat (byte_dat),
        .base     (commit_base_o),
        .mask     (commit_mask_o),
        .data     (commit_data_o),
        .any_byte (any_byte)
    );
endmodule

// File: rtl/pgwr_commit_chk.sv
module pgwr_commit_chk #(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n,
    input logic                  commit_o,
    input logic                  commit_sr_o,
    input logic [PAGE_BYTES-1:0] commit_mask_o,
    input logic                  wel_set_o
);
    // R9: request lasts a single cycle
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    // R9: request follows the first high sample of chip select
    p_after_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> ($past(cs_n) && !$past(cs_n, 2)));

    // R2: a page commit never has an empty lane mask
    p_page_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && !commit_sr_o) |-> (|commit_mask_o));

    // R7: write-enable flag and commit never coincide
    p_one_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_o, wel_set_o}));

    // R6: status flag only with a commit
    p_sr_with_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_sr_o |-> commit_o);

    // R8: lane mask frozen while deselected
    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> $stable(commit_mask_o));
endmodule

bind pgwr_commit pgwr_commit_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) chk_i (.*);

// File: tb/pgwr_commit_tb.sv
module pgwr_commit_tb_top;
    localparam int AW = 15;
    localparam int PB = 64;
    localparam int DW = PB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          bit_stb = 1'b0;
    logic          byte_stb = 1'b0;
    logic [7:0]    byte_dat = '0;
    logic          commit_o, commit_sr_o, wel_set_o;
    logic [AW-1:0] commit_base_o;
    logic [PB-1:0] commit_mask_o;
    logic [DW-1:0] commit_data_o;
    logic [7:0]    sr_data_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pgwr_commit #(.ADDR_W(AW), .PAGE_BYTES(PB)) dut_i (.*);

    task automatic check(input logic ok, input string tag,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_bits(input logic [7:0] v, input int nb);
        for (int i = 0; i < nb; i++) begin
            bit_stb  = 1'b1;
            byte_stb = (i == 7);
            byte_dat = v;
            @(negedge clk);
        end
        bit_stb  = 1'b0;
        byte_stb = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v);
        put_bits(v, 8);
    endtask

    task automatic select;
        cs_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic close_seq(input logic ec, input logic esr, input logic ew, input string tag);
        cs_n = 1'b1;
        @(negedge clk);
        check(commit_o == ec, {tag, " commit"}, DW'(commit_o), DW'(ec));
        check(commit_sr_o == esr, {tag, " sr flag"}, DW'(commit_sr_o), DW'(esr));
        check(wel_set_o == ew, {tag, " wel"}, DW'(wel_set_o), DW'(ew));
        @(negedge clk);
        check(!commit_o && !wel_set_o, "R9 pulse width", DW'({commit_o, wel_set_o}), '0);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] exp_d, lane_m, got_d;
        logic [PB-1:0] exp_m;
        logic [8:0]    pg;
        logic [5:0]    ofs;
        int            offs [3];
        offs[0] = 0; offs[1] = 5; offs[2] = 63;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!commit_o && !commit_sr_o && !wel_set_o, "R1 reset pulses",
              DW'({commit_o, commit_sr_o, wel_set_o}), '0);
        check(commit_mask_o == '0, "R1 reset mask", DW'(commit_mask_o), '0);

        // R2 R3 R8 R11 sweep
        for (int oi = 0; oi < 3; oi++) begin
            for (int n = 1; n <= 70; n++) begin
                pg  = 9'((n * 3 + oi * 101) % 512);
                ofs = 6'(offs[oi]);
                exp_m = '0;
                exp_d = '0;
                select();
                put_byte(8'h02);
                put_byte({1'b1, pg[8:2]});
                put_byte({pg[1:0], ofs});
                for (int k = 0; k < n; k++) begin
                    int pos;
                    logic [7:0] v;
                    pos = (offs[oi] + k) % PB;
                    v = 8'((k * 37 + offs[oi] + n) & 255);
                    exp_m[pos] = 1'b1;
                    exp_d[pos*8 +: 8] = v;
                    put_byte(v);
                end
                close_seq(1'b1, 1'b0, 1'b0, "R2 page write");
                check(commit_base_o == {pg, 6'b0}, "R11 base",
                      DW'(commit_base_o), DW'({pg, 6'b0}));
                check(commit_mask_o == exp_m, "R8 lane mask",
                      DW'(commit_mask_o), DW'(exp_m));
                lane_m = '0;
                for (int j = 0; j < PB; j++) if (exp_m[j]) lane_m[j*8 +: 8] = 8'hFF;
                got_d = commit_data_o & lane_m;
                check(got_d == exp_d, (n > PB - offs[oi]) ? "R3 wrapped data" : "R2 data",
                      got_d, exp_d);
            end
        end

        // R4 partial final byte
        for (int pb = 1; pb <= 7; pb++) begin
            select();
            put_byte(8'h02); put_byte(8'h01); put_byte(8'h10);
            put_byte(8'hA5); put_byte(8'h5A);
            put_bits(8'h33, pb);
            close_seq(1'b0, 1'b0, 1'b0, "R4 mid-byte release");
        end

        // R5 early releases
        select(); put_byte(8'h02);
        close_seq(1'b0, 1'b0, 1'b0, "R5 opcode only");
        select(); put_byte(8'h02); put_byte(8'h00);
        close_seq(1'b0, 1'b0, 1'b0, "R5 half address");
        select(); put_byte(8'h02); put_byte(8'h00); put_byte(8'h40);
        close_seq(1'b0, 1'b0, 1'b0, "R5 address only");
        select(); put_byte(8'h02); put_byte(8'h00); put_bits(8'h40, 3);
        close_seq(1'b0, 1'b0, 1'b0, "R5 mid address");

        // R6 all status values
        for (int v = 0; v < 256; v++) begin
            select(); put_byte(8'h01); put_byte(8'(v));
            close_seq(1'b1, 1'b1, 1'b0, "R6 status write");
            check(sr_data_o == (8'(v) & 8'h9C), "R6 status bits",
                  DW'(sr_data_o), DW'(8'(v) & 8'h9C));
        end
        select(); put_byte(8'h01); put_byte(8'hFF); put_bits(8'h00, 1);
        close_seq(1'b0, 1'b0, 1'b0, "R6 extra bit");
        select(); put_byte(8'h01); put_byte(8'hFF); put_byte(8'h80);
        close_seq(1'b0, 1'b0, 1'b0, "R6 extra byte");
        select(); put_byte(8'h01); put_bits(8'hFF, 4);
        close_seq(1'b0, 1'b0, 1'b0, "R6 short byte");

        // R7 write enable
        select(); put_byte(8'h06);
        close_seq(1'b0, 1'b0, 1'b1, "R7 clean enable");
        select(); put_byte(8'h06); put_byte(8'h02); put_byte(8'h00);
        put_byte(8'h00); put_byte(8'h11);
        close_seq(1'b0, 1'b0, 1'b0, "R7 enable then write");
        select(); put_byte(8'h06); put_bits(8'h00, 2);
        close_seq(1'b0, 1'b0, 1'b0, "R7 enable plus bits");

        // R10 other opcodes
        for (int op = 3; op <= 5; op++) begin
            select(); put_byte(8'(op)); put_byte(8'h00); put_byte(8'h00); put_byte(8'h77);
            close_seq(1'b0, 1'b0, 1'b0, "R10 foreign opcode");
        end
        select(); put_byte(8'h82); put_byte(8'h00); put_byte(8'h00); put_byte(8'h77);
        close_seq(1'b0, 1'b0, 1'b0, "R10 near-miss opcode");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule